// File: doc/BRIEF.md
# Two-Port Shared Memory with Same-Address Contention Arbitration

This block is a clocked two-port memory of 4096 words whose word width is set to 8 or 9 bits. A left port and a right port each carry their own active-low select, read/write control and output enable. The two ports address the whole array independently, and in any cycle each port can read or write.

When both ports are selected on the same word in one cycle and at least one of them is writing, the block grants the word to a single port. It raises the busy flag of the other port and blocks that port's write. The grant stays with the winning port for as long as it remains on the word. Reads are never blocked. Both ports may read one word together with no busy flag.

A mode input picks between two roles. As a master, the block arbitrates and drives its busy outputs. As a slave, it does no arbitration of its own. It takes busy from its busy inputs, which are wired from a master's busy outputs, and copies them to its busy outputs. Several devices can then be placed side by side to form a wider word under one decision.

Top module: `dpram_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both read data outputs are zero and, with both ports deselected, both busy outputs are low.
- R2: A word written through either port (rw_n = 0 while selected) can be read through either port. Read data appears on the clock edge that follows the cycle in which the read address was presented, and all DATA_W bits are stored.
- R3: In master mode, when both ports read the same word in the same cycle, neither busy output is raised and both ports return the stored word.
- R4: In master mode, the two busy outputs are never high together. A busy output is high only in a cycle in which both ports are selected on the same word and at least one of them is writing.
- R5: In master mode, when both ports arrive at a contested word in the same cycle, the left port wins and only r_busy_out is raised.
- R6: In master mode, a port that was already selected on the word in the previous cycle wins against a port that has just arrived. The loser's busy stays high while the winner stays on the word. It drops in the first cycle in which the winner has left or is deselected.
- R7: A write from a port whose busy output is high in that cycle leaves the memory unchanged. A read from the winning port meanwhile returns the old contents.
- R8: In slave mode (master_mode = 0), each busy output equals the same port's busy input in the same cycle, and no arbitration takes place. A write with its busy input high is blocked.
- R9: A port whose chip select is high is idle: it takes no part in arbitration, and the other port then never sees busy.
- R10: Read data is zero in the cycle after a port was deselected, was writing, or had its output enable high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | 1: arbitrate and drive busy; 0: slave, busy taken from inputs |
| l_cs_n | input | 1 | Left chip select, active low |
| l_rw_n | input | 1 | Left direction: 1 read, 0 write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data, registered |
| l_busy_in | input | 1 | Left busy from a master (slave mode only) |
| l_busy_out | output | 1 | Left busy flag |
| r_cs_n | input | 1 | Right chip select, active low |
| r_rw_n | input | 1 | Right direction: 1 read, 0 write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data, registered |
| r_busy_in | input | 1 | Right busy from a master (slave mode only) |
| r_busy_out | output | 1 | Right busy flag |

## Verification
The assertions assume that the inputs are stable and defined around each rising edge. They assume that master_mode changes only at cycle boundaries. They assume that in slave mode the busy inputs come from a master, so they are never both high. The stimulus changes every input just after a rising edge. It drives the busy inputs only one side at a time, and only while in slave mode. It reads back only words it has already written, so no undefined memory contents reach the compared outputs.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    // Which side currently holds a contested word
    typedef enum logic [1:0] {
        SIDE_NONE  = 2'd0,
        SIDE_LEFT  = 2'd1,
        SIDE_RIGHT = 2'd2
    } side_e;

    localparam int unsigned N_SIDES = 2;
    localparam int unsigned LEFT_IX  = 0;
    localparam int unsigned RIGHT_IX = 1;

endpackage

// File: rtl/dpram_arb_core.sv
module dpram_arb_core
    import dpram_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              l_en,
    input  logic              l_wr,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_busy_in,
    input  logic              r_en,
    input  logic              r_wr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_busy_in,
    output logic              l_busy,
    output logic              r_busy,
    output logic              l_we,
    output logic              r_we
);

    typedef struct packed {
        side_e             owner;
        logic [ADDR_W-1:0] hold_addr;
        logic              l_seen;
        logic [ADDR_W-1:0] l_seen_addr;
        logic              r_seen;
        logic [ADDR_W-1:0] r_seen_addr;
    } arb_state_t;

    arb_state_t st_q, st_d;

    logic  clash;
    logic  l_stayed, r_stayed;
    side_e winner;

    always_comb begin
        st_d     = st_q;
        clash    = l_en && r_en && (l_addr == r_addr) && (l_wr || r_wr);
        l_stayed = st_q.l_seen && (st_q.l_seen_addr == l_addr);
        r_stayed = st_q.r_seen && (st_q.r_seen_addr == r_addr);
        winner   = SIDE_NONE;

        if (clash) begin
            if (st_q.owner != SIDE_NONE && st_q.hold_addr == l_addr) begin
                winner = st_q.owner;
            end else if (r_stayed && !l_stayed) begin
                winner = SIDE_RIGHT;
            end else begin
                winner = SIDE_LEFT;
            end
        end

        if (master_mode) begin
            l_busy = (winner == SIDE_RIGHT);
            r_busy = (winner == SIDE_LEFT);
        end else begin
            l_busy = l_busy_in;
            r_busy = r_busy_in;
        end

        l_we = l_en && l_wr && !l_busy;
        r_we = r_en && r_wr && !r_busy;

        st_d.owner       = winner;
        st_d.hold_addr   = l_addr;
        st_d.l_seen      = l_en;
        st_d.l_seen_addr = l_addr;
        st_d.r_seen      = r_en;
        st_d.r_seen_addr = r_addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: one loser at most
    p_busy_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        master_mode |-> !(l_busy && r_busy));

    // R9: a deselected side causes no busy
    p_idle_no_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && (!l_en || !r_en)) |-> (!l_busy && !r_busy));

    // R3: shared reads never flag busy
    p_shared_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && l_en && r_en && !l_wr && !r_wr) |-> (!l_busy && !r_busy));

    // R8: slave copies busy inputs
    p_slave_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> (l_busy == l_busy_in && r_busy == r_busy_in));

    // R7: a flagged side never writes
    p_blocked_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (l_busy |-> !l_we) and (r_busy |-> !r_we));

    // R5: a fresh tie is granted to the left side
    p_tie_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && clash && st_q.owner == SIDE_NONE && l_stayed == r_stayed)
        |-> (r_busy && !l_busy));

endmodule

// File: rtl/dpram_store.sv
module dpram_store
    import dpram_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 9
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [N_SIDES-1:0]                rd_req,
    input  logic [N_SIDES-1:0]                we,
    input  logic [N_SIDES-1:0][ADDR_W-1:0]    addr,
    input  logic [N_SIDES-1:0][DATA_W-1:0]    wdata,
    output logic [N_SIDES-1:0][DATA_W-1:0]    rdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Right first, left last: left data survives a double write
    always_ff @(posedge clk) begin
        if (we[RIGHT_IX]) mem[addr[RIGHT_IX]] <= wdata[RIGHT_IX];
        if (we[LEFT_IX])  mem[addr[LEFT_IX]]  <= wdata[LEFT_IX];
    end

    for (genvar s = 0; s < N_SIDES; s++) begin : g_rd
        typedef struct packed {
            logic [DATA_W-1:0] data;
        } rd_state_t;

        rd_state_t rd_q, rd_d;

        always_comb begin
            rd_d      = rd_q;
            rd_d.data = rd_req[s] ? mem[addr[s]] : '0;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_q <= '0;
            end else begin
                rd_q <= rd_d;
            end
        end

        assign rdata[s] = rd_q.data;

        // R10: a quiet cycle yields zero data on the next edge
        p_rdata_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_req[s] |=> (rdata[s] == '0));
    end

endmodule

// File: rtl/dpram_arbiter.sv
module dpram_arbiter
    import dpram_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              l_cs_n,
    input  logic              l_rw_n,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              l_busy_in,
    output logic              l_busy_out,
    input  logic              r_cs_n,
    input  logic              r_rw_n,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    input  logic              r_busy_in,
    output logic              r_busy_out
);

    logic l_en, r_en, l_wr, r_wr, l_we, r_we;

    logic [N_SIDES-1:0]             rd_req, we_vec;
    logic [N_SIDES-1:0][ADDR_W-1:0] addr_vec;
    logic [N_SIDES-1:0][DATA_W-1:0] wdata_vec, rdata_vec;

    assign l_en = !l_cs_n;
    assign r_en = !r_cs_n;
    assign l_wr = !l_rw_n;
    assign r_wr = !r_rw_n;

    dpram_arb_core #(.ADDR_W(ADDR_W)) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_mode (master_mode),
        .l_en        (l_en),
        .l_wr        (l_wr),
        .l_addr      (l_addr),
        .l_busy_in   (l_busy_in),
        .r_en        (r_en),
        .r_wr        (r_wr),
        .r_addr      (r_addr),
        .r_busy_in   (r_busy_in),
        .l_busy      (l_busy_out),
        .r_busy      (r_busy_out),
        .l_we        (l_we),
        .r_we        (r_we)
    );

    assign rd_req[LEFT_IX]    = l_en && !l_wr && !l_oe_n;
    assign rd_req[RIGHT_IX]   = r_en && !r_wr && !r_oe_n;
    assign we_vec[LEFT_IX]    = l_we;
    assign we_vec[RIGHT_IX]   = r_we;
    assign addr_vec[LEFT_IX]  = l_addr;
    assign addr_vec[RIGHT_IX] = r_addr;
    assign wdata_vec[LEFT_IX] = l_wdata;
    assign wdata_vec[RIGHT_IX] = r_wdata;

    dpram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_req (rd_req),
        .we     (we_vec),
        .addr   (addr_vec),
        .wdata  (wdata_vec),
        .rdata  (rdata_vec)
    );

    assign l_rdata = rdata_vec[LEFT_IX];
    assign r_rdata = rdata_vec[RIGHT_IX];

    // R1: outputs quiet right after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (l_rdata == '0 && r_rdata == '0));

endmodule

// File: tb/dpram_arbiter_bench.sv
module dpram_arbiter_bench;

    localparam int AW = 12;
    localparam int DW = 9;

    logic clk = 1'b0;
    logic rst_n;
    logic master_mode;
    logic l_cs_n, l_rw_n, l_oe_n, l_busy_in;
    logic r_cs_n, r_rw_n, r_oe_n, r_busy_in;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_wdata, r_wdata;
    logic [DW-1:0] l_rdata, r_rdata;
    logic l_busy_out, r_busy_out;

    always #4 clk = ~clk;

    dpram_arbiter #(.ADDR_W(AW), .DATA_W(DW)) u_dpram_arbiter (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .l_cs_n(l_cs_n), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(l_rdata), .l_busy_in(l_busy_in), .l_busy_out(l_busy_out),
        .r_cs_n(r_cs_n), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_rdata(r_rdata), .r_busy_in(r_busy_in), .r_busy_out(r_busy_out)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference
    logic [DW-1:0] ref_mem [1 << AW];
    bit            grant_live;
    bit            grant_right;
    int            grant_word;
    bit            l_was_on, r_was_on;
    int            l_was_at, r_was_at;
    logic [DW-1:0] exp_lr, exp_rr;
    logic          last_lb, last_rb;
    logic [DW-1:0] last_lr, last_rr;

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // One cycle: inputs already set just after a rising edge
    task automatic cyc();
        bit lon, ron, lw, rw, clash, right_wins, eb_l, eb_r;
        #2;
        lon = !l_cs_n; ron = !r_cs_n; lw = !l_rw_n; rw = !r_rw_n;
        clash = lon && ron && (l_addr == r_addr) && (lw || rw);
        right_wins = 0;
        if (clash) begin
            if (grant_live && int'(l_addr) == grant_word)
                right_wins = grant_right;
            else
                right_wins = (r_was_on && r_was_at == int'(r_addr)) &&
                             !(l_was_on && l_was_at == int'(l_addr));
        end
        if (master_mode) begin
            eb_l = clash && right_wins;
            eb_r = clash && !right_wins;
        end else begin
            eb_l = l_busy_in;
            eb_r = r_busy_in;
        end
        last_lb = l_busy_out;
        last_rb = r_busy_out;
        chk(master_mode ? "R4 left busy" : "R8 left busy", {8'd0, l_busy_out}, {8'd0, eb_l});
        chk(master_mode ? "R4 right busy" : "R8 right busy", {8'd0, r_busy_out}, {8'd0, eb_r});
        exp_lr = (lon && !lw && !l_oe_n) ? ref_mem[l_addr] : '0;
        exp_rr = (ron && !rw && !r_oe_n) ? ref_mem[r_addr] : '0;
        @(posedge clk);
        #1;
        if (ron && rw && !eb_r) ref_mem[r_addr] = r_wdata;
        if (lon && lw && !eb_l) ref_mem[l_addr] = l_wdata;
        grant_live  = clash;
        grant_right = right_wins;
        grant_word  = int'(l_addr);
        l_was_on = lon; l_was_at = int'(l_addr);
        r_was_on = ron; r_was_at = int'(r_addr);
        last_lr = l_rdata;
        last_rr = r_rdata;
        chk("R2 left rdata", l_rdata, exp_lr);
        chk("R2 right rdata", r_rdata, exp_rr);
    endtask

    task automatic drv_l(input bit on, input bit wr, input bit oe, input int a, input int d);
        l_cs_n = !on; l_rw_n = !wr; l_oe_n = !oe; l_addr = AW'(a); l_wdata = DW'(d);
    endtask

    task automatic drv_r(input bit on, input bit wr, input bit oe, input int a, input int d);
        r_cs_n = !on; r_rw_n = !wr; r_oe_n = !oe; r_addr = AW'(a); r_wdata = DW'(d);
    endtask

    task automatic idle_both();
        drv_l(0, 0, 0, 0, 0);
        drv_r(0, 0, 0, 0, 0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        grant_live = 0; grant_right = 0; grant_word = 0;
        l_was_on = 0; r_was_on = 0; l_was_at = 0; r_was_at = 0;
        rst_n = 0; master_mode = 1; l_busy_in = 0; r_busy_in = 0;
        idle_both();
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset left rdata", l_rdata, '0);
        chk("R1 reset right rdata", r_rdata, '0);
        rst_n = 1;
        cyc();
        chk("R1 left busy after reset", {8'd0, last_lb}, 9'd0);
        chk("R1 right busy after reset", {8'd0, last_rb}, 9'd0);

        // R2: full-width write, read one cycle later through the other port
        drv_l(1, 1, 0, 5, 9'h1A5); cyc();
        idle_both(); drv_r(1, 0, 1, 5, 0); cyc();
        chk("R2 right reads left write", last_rr, 9'h1A5);

        for (int i = 0; i < 8; i++) begin
            drv_l(1, 1, 0, 100 + i, i * 37 + 3);
            drv_r(1, 1, 0, 200 + i, 511 - i * 29);
            cyc();
        end
        for (int i = 0; i < 8; i++) begin
            drv_l(1, 0, 1, 200 + i, 0);
            drv_r(1, 0, 1, 100 + i, 0);
            cyc();
            chk("R2 left readback", last_lr, DW'(511 - i * 29));
            chk("R2 right readback", last_rr, DW'(i * 37 + 3));
        end

        // R3: shared read
        drv_l(1, 0, 1, 5, 0); drv_r(1, 0, 1, 5, 0); cyc();
        chk("R3 no left busy", {8'd0, last_lb}, 9'd0);
        chk("R3 no right busy", {8'd0, last_rb}, 9'd0);
        chk("R3 left data", last_lr, 9'h1A5);

        // R5 and R7: simultaneous write, left wins
        drv_l(1, 1, 0, 50, 9'h011); drv_r(1, 1, 0, 50, 9'h022); cyc();
        chk("R5 right busy", {8'd0, last_rb}, 9'd1);
        chk("R5 left not busy", {8'd0, last_lb}, 9'd0);
        idle_both(); drv_l(1, 0, 1, 50, 0); cyc();
        chk("R7 right write blocked", last_lr, 9'h011);

        // R6 and R7: first arrival holds the word
        idle_both(); drv_l(1, 1, 0, 60, 9'h033); cyc();
        idle_both(); drv_r(1, 0, 1, 60, 0); cyc();
        drv_l(1, 1, 0, 60, 9'h044); cyc();
        chk("R6 late writer busy", {8'd0, last_lb}, 9'd1);
        cyc();
        chk("R6 busy held", {8'd0, last_lb}, 9'd1);
        chk("R7 old data while blocked", last_rr, 9'h033);
        drv_r(0, 0, 0, 60, 0); cyc();
        chk("R6 busy released", {8'd0, last_lb}, 9'd0);
        idle_both(); drv_r(1, 0, 1, 60, 0); cyc();
        chk("R6 write after release", last_rr, 9'h044);

        // R9: deselected side does not arbitrate
        drv_l(0, 1, 0, 60, 9'h0EE); drv_r(1, 1, 0, 60, 9'h055); cyc();
        chk("R9 no right busy", {8'd0, last_rb}, 9'd0);
        idle_both(); drv_l(1, 0, 1, 60, 0); cyc();
        chk("R9 right write landed", last_lr, 9'h055);

        // R10: output enable high and write cycles give zero
        drv_l(1, 0, 0, 60, 0); drv_r(1, 1, 1, 61, 9'h0AA); cyc();
        chk("R10 oe off", last_lr, '0);
        chk("R10 write cycle", last_rr, '0);

        // R8: slave mode
        idle_both(); drv_l(1, 1, 0, 70, 9'h077); cyc();
        master_mode = 0; l_busy_in = 1;
        drv_l(1, 1, 0, 70, 9'h066); drv_r(0, 0, 0, 0, 0); cyc();
        chk("R8 busy follows input", {8'd0, last_lb}, 9'd1);
        l_busy_in = 0; idle_both(); drv_l(1, 0, 1, 70, 0); cyc();
        chk("R8 blocked slave write", last_lr, 9'h077);
        drv_l(1, 1, 0, 71, 9'h101); drv_r(1, 1, 0, 71, 9'h102); cyc();
        chk("R8 no own arbitration", {8'd0, last_rb}, 9'd0);
        r_busy_in = 1; drv_l(0, 0, 0, 0, 0); drv_r(1, 1, 0, 72, 9'h003); cyc();
        chk("R8 right busy input", {8'd0, last_rb}, 9'd1);
        r_busy_in = 0; master_mode = 1; idle_both(); drv_r(1, 0, 1, 71, 0); cyc();
        chk("R8 left data kept on double write", last_rr, 9'h101);

        idle_both(); cyc();
        finish_run();
    end

endmodule